// File: doc/BRIEF.md
# Speculative Load Ordering Checker

This block keeps a window of in-flight loads in program order so that loads may run ahead of older stores whose addresses are still unknown. Each load takes a slot when it is dispatched and receives a tag. When the load executes, the block records the word it touched and marks it done. Later, when an older store learns its address, the store's address and its age boundary are broadcast. Every done load at or beyond that boundary that touched the same word is marked as having read stale data.

The mark has no effect until the load reaches the oldest slot and the commit stage asks to retire it. A clean load then retires quietly. A marked load retires with a flush request that carries its instruction address, so that a dependence predictor can be trained and the load fetched again. The flush also discards every younger slot. The pipeline recovery and the store-to-load data path belong to other blocks.

Top module: `lq_violation_detector`

## Requirements
- R1: After synchronous reset the window is empty: `alloc_rdy` is 1, `alloc_tag` is 0, and `cmt_ok` and `flush_vld` stay 0 even while `cmt_req` is high.
- R2: The window holds 32 loads. `alloc_rdy` is 0 exactly while 32 slots are occupied. A request made while full is ignored: no slot is taken and `alloc_tag` does not move.
- R3: A report on `exe_vld` marks the load named by `exe_tag` done and records its address. A report naming a slot that holds no load is ignored.
- R4: `cmt_ok` is 1 in the cycle that `cmt_req` is high and the oldest slot holds a done load. That load leaves the window at the next edge. An empty window or an unfinished oldest load gives `cmt_ok` = 0.
- R5: A store broadcast (`sta_vld`) marks a load when all of these hold: the load is done; its tag is at or after `sta_tag` in age; and bits [31:2] of its address equal bits [31:2] of `sta_addr`. Loads older than `sta_tag`, and loads in a different 4-byte word, are not marked.
- R6: A load whose execution report arrives in the same cycle as a matching store broadcast is marked.
- R7: When `cmt_ok` retires a marked load, `flush_vld` is 1 in that same cycle and `flush_pc` equals the address given when that load was allocated.
- R8: A flush empties the window. A request made in the flush cycle is discarded. The next tag handed out is the flushed load's tag plus one.
- R9: Tags are 6 bits: a 5-bit slot index plus a wrap bit. They count up by one per allocation modulo 64, and the age test stays correct when the tags wrap.
- R10: A load that is not done when a store broadcast arrives is not marked by it, even if the load later executes to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Allocate a slot for the next load in program order |
| alloc_pc | input | 32 | Instruction address of the allocated load |
| alloc_rdy | output | 1 | A free slot exists |
| alloc_tag | output | 6 | Tag that the next allocation receives |
| exe_vld | input | 1 | A load has executed |
| exe_tag | input | 6 | Tag of the executed load |
| exe_addr | input | 32 | Byte address the load read |
| sta_vld | input | 1 | A store address has resolved |
| sta_tag | input | 6 | Tag of the first load younger than the store |
| sta_addr | input | 32 | Resolved store byte address |
| cmt_req | input | 1 | Commit stage wants to retire the oldest load |
| cmt_ok | output | 1 | Oldest load retires this cycle |
| flush_vld | output | 1 | Retiring load read stale data; flush younger work |
| flush_pc | output | 32 | Instruction address of the load that forces the flush |

## Verification
Two cases need care. In the first, an execution report and a matching store broadcast fall in the same cycle, and the store must see the load's new address before that address is stored. In the second, a flush and a new allocation fall in the same cycle, and the allocation must be discarded. The bench provokes the first case by often copying the executing load's address into the store and placing the store's age boundary at or before that load. It provokes the second case by keeping allocation requests dense while marked loads commit. A queue-based model, which decides age by unbounded sequence numbers, gives the expected ready flag, tag, retire and flush outputs on every clock.

// File: rtl/lq_pkg.sv
package lq_pkg;
    localparam int LQ_DEPTH = 32;
    localparam int IDX_W    = $clog2(LQ_DEPTH);
    localparam int TAG_W    = IDX_W + 1;
    localparam int ADDR_W   = 32;
    localparam int PC_W     = 32;
    localparam int WORD_LSB = 2;
    localparam int WADDR_W  = ADDR_W - WORD_LSB;

    typedef logic [TAG_W-1:0]   lq_tag_t;
    typedef logic [IDX_W-1:0]   lq_idx_t;
    typedef logic [WADDR_W-1:0] lq_waddr_t;

    typedef struct packed {
        logic            busy;
        logic            done;
        logic            trap;
        lq_waddr_t       waddr;
        logic [PC_W-1:0] pc;
    } lq_ent_t;

    function automatic lq_waddr_t word_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:WORD_LSB];
    endfunction

    function automatic lq_idx_t slot_of(input lq_tag_t t);
        return t[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/lq_ptrs.sv
module lq_ptrs
    import lq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  logic    pop,
    input  logic    flush,
    output lq_tag_t head_tag,
    output lq_tag_t tail_tag,
    output logic    full
);
    lq_tag_t used;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_tag <= '0;
            tail_tag <= '0;
        end else if (flush) begin
            // the flagged load leaves; everything behind it is dropped
            head_tag <= head_tag + 1'b1;
            tail_tag <= head_tag + 1'b1;
        end else begin
            if (pop)  head_tag <= head_tag + 1'b1;
            if (push) tail_tag <= tail_tag + 1'b1;
        end
    end

    assign used = tail_tag - head_tag;
    assign full = (used == lq_tag_t'(LQ_DEPTH));
endmodule

// File: rtl/lq_match_vec.sv
module lq_match_vec
    import lq_pkg::*;
(
    input  lq_ent_t [LQ_DEPTH-1:0] ents,
    input  lq_tag_t                head_tag,
    input  logic                   sta_vld,
    input  lq_tag_t                sta_tag,
    input  lq_waddr_t              sta_word,
    input  logic                   exe_vld,
    input  lq_idx_t                exe_slot,
    input  lq_waddr_t              exe_word,
    output logic [LQ_DEPTH-1:0]    hit
);
    // distance of the store's age boundary from the oldest slot
    lq_tag_t store_ofs;
    assign store_ofs = sta_tag - head_tag;

    for (genvar i = 0; i < LQ_DEPTH; i++) begin : g_ent
        lq_idx_t   ent_ofs;
        logic      fin_now;
        logic      done_eff;
        logic      younger;
        lq_waddr_t word_eff;

        assign ent_ofs  = lq_idx_t'(i) - head_tag[IDX_W-1:0];
        // a load finishing this very cycle is compared with its fresh address
        assign fin_now  = exe_vld && (exe_slot == lq_idx_t'(i));
        assign done_eff = ents[i].done || fin_now;
        assign word_eff = fin_now ? exe_word : ents[i].waddr;
        assign younger  = {1'b0, ent_ofs} >= store_ofs;
        assign hit[i]   = sta_vld && ents[i].busy && done_eff && younger
                          && (word_eff == sta_word);
    end
endmodule

// File: rtl/lq_violation_detector.sv
module lq_violation_detector
    import lq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_vld,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic              alloc_rdy,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              exe_vld,
    input  logic [TAG_W-1:0]  exe_tag,
    input  logic [ADDR_W-1:0] exe_addr,
    input  logic              sta_vld,
    input  logic [TAG_W-1:0]  sta_tag,
    input  logic [ADDR_W-1:0] sta_addr,
    input  logic              cmt_req,
    output logic              cmt_ok,
    output logic              flush_vld,
    output logic [PC_W-1:0]   flush_pc
);
    lq_ent_t [LQ_DEPTH-1:0] ents;
    lq_tag_t                head_tag;
    lq_tag_t                tail_tag;
    logic                   full;
    logic                   push;
    logic                   exe_take;
    lq_idx_t                head_slot;
    lq_idx_t                tail_slot;
    lq_idx_t                exe_slot;
    lq_waddr_t              exe_word;
    lq_waddr_t              sta_word;
    logic [LQ_DEPTH-1:0]    hit;
    lq_ent_t                head_ent;
    logic                   head_done;
    logic                   head_trap;

    assign head_slot = slot_of(head_tag);
    assign tail_slot = slot_of(tail_tag);
    assign exe_slot  = slot_of(exe_tag);
    assign exe_word  = word_of(exe_addr);
    assign sta_word  = word_of(sta_addr);

    assign head_ent  = ents[head_slot];
    assign head_done = head_ent.busy && head_ent.done;
    assign head_trap = head_ent.busy && head_ent.trap;

    assign cmt_ok    = cmt_req && head_done;
    assign flush_vld = cmt_ok && head_ent.trap;
    assign flush_pc  = head_ent.pc;

    assign alloc_rdy = !full;
    assign alloc_tag = tail_tag;
    assign push      = alloc_vld && !full && !flush_vld;
    assign exe_take  = exe_vld && ents[exe_slot].busy;

    lq_ptrs u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (cmt_ok),
        .flush    (flush_vld),
        .head_tag (head_tag),
        .tail_tag (tail_tag),
        .full     (full)
    );

    lq_match_vec u_match (
        .ents     (ents),
        .head_tag (head_tag),
        .sta_vld  (sta_vld),
        .sta_tag  (sta_tag),
        .sta_word (sta_word),
        .exe_vld  (exe_take),
        .exe_slot (exe_slot),
        .exe_word (exe_word),
        .hit      (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ents <= '0;
        end else if (flush_vld) begin
            for (int i = 0; i < LQ_DEPTH; i++) ents[i].busy <= 1'b0;
        end else begin
            for (int i = 0; i < LQ_DEPTH; i++) begin
                if (hit[i]) ents[i].trap <= 1'b1;
            end
            if (exe_take) begin
                ents[exe_slot].done  <= 1'b1;
                ents[exe_slot].waddr <= exe_word;
            end
            if (cmt_ok) ents[head_slot].busy <= 1'b0;
            if (push) begin
                ents[tail_slot] <= '{busy: 1'b1, done: 1'b0, trap: 1'b0,
                                     waddr: '0, pc: alloc_pc};
            end
        end
    end
endmodule

// File: rtl/lq_chk.sv
module lq_chk (
    input logic clk,
    input logic rst,
    input logic alloc_rdy,
    input logic cmt_req,
    input logic cmt_ok,
    input logic flush_vld,
    input logic head_done,
    input logic head_trap
);
    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!alloc_rdy && !cmt_ok) |=> !alloc_rdy);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush_vld |=> (alloc_rdy && !cmt_ok));

    // R4
    retire_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (cmt_req && !head_done) |-> !cmt_ok);

    // R5
    mark_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (head_trap && !cmt_ok) |=> head_trap);

    // R7
    flush_marked_chk: assert property (@(posedge clk) disable iff (rst)
        flush_vld |-> head_trap);
endmodule

bind lq_violation_detector lq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .alloc_rdy (alloc_rdy),
    .cmt_req   (cmt_req),
    .cmt_ok    (cmt_ok),
    .flush_vld (flush_vld),
    .head_done (head_done),
    .head_trap (head_trap)
);

// File: tb/lq_violation_detector_tb.sv
module lq_violation_detector_tb;
    import lq_pkg::*;

    localparam int CLK_P   = 10;
    localparam int NTAG    = 2 * LQ_DEPTH;
    localparam int WDOG    = 20000;

    logic              clk = 1'b0;
    logic              rst;
    logic              alloc_vld;
    logic [PC_W-1:0]   alloc_pc;
    logic              alloc_rdy;
    logic [TAG_W-1:0]  alloc_tag;
    logic              exe_vld;
    logic [TAG_W-1:0]  exe_tag;
    logic [ADDR_W-1:0] exe_addr;
    logic              sta_vld;
    logic [TAG_W-1:0]  sta_tag;
    logic [ADDR_W-1:0] sta_addr;
    logic              cmt_req;
    logic              cmt_ok;
    logic              flush_vld;
    logic [PC_W-1:0]   flush_pc;

    always #(CLK_P/2) clk = ~clk;

    lq_violation_detector u_dut (
        .clk(clk), .rst(rst),
        .alloc_vld(alloc_vld), .alloc_pc(alloc_pc), .alloc_rdy(alloc_rdy), .alloc_tag(alloc_tag),
        .exe_vld(exe_vld), .exe_tag(exe_tag), .exe_addr(exe_addr),
        .sta_vld(sta_vld), .sta_tag(sta_tag), .sta_addr(sta_addr),
        .cmt_req(cmt_req), .cmt_ok(cmt_ok), .flush_vld(flush_vld), .flush_pc(flush_pc)
    );

    typedef struct {
        int                seq;
        logic [PC_W-1:0]   pc;
        bit                done;
        bit                trap;
        logic [ADDR_W-1:0] addr;
    } mdl_t;

    mdl_t mq[$];
    int   next_seq;
    int   checks;
    int   errors;
    bit   finished;
    int   n_flush;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] pick_addr();
        case ($urandom % 6)
            0: return 32'h40;
            1: return 32'h41;
            2: return 32'h43;
            3: return 32'h44;
            4: return 32'h47;
            default: return 32'h80;
        endcase
    endfunction

    task automatic step(input int p_alloc, input int p_exe, input int p_sta, input int p_cmt);
        int head_seq;
        int exe_seq;
        int st_seq;
        int pend[$];
        bit exp_rdy;
        bit exp_ok;
        bit exp_fl;
        @(negedge clk);
        head_seq  = (mq.size() > 0) ? mq[0].seq : next_seq;
        alloc_vld = (($urandom % 100) < p_alloc);
        alloc_pc  = $urandom;
        exe_seq   = -1;
        exe_vld   = 1'b0;
        exe_tag   = '0;
        exe_addr  = pick_addr();
        if (($urandom % 100) < p_exe) begin
            foreach (mq[k]) if (!mq[k].done) pend.push_back(mq[k].seq);
            if (pend.size() > 0) begin
                exe_seq = pend[$urandom % pend.size()];
                exe_vld = 1'b1;
                exe_tag = lq_tag_t'(exe_seq % NTAG);
            end else if (mq.size() < LQ_DEPTH) begin
                // R3: report names a free slot and must be ignored
                exe_vld = 1'b1;
                exe_tag = lq_tag_t'(next_seq % NTAG);
            end
        end
        sta_vld  = (($urandom % 100) < p_sta);
        st_seq   = head_seq + int'($urandom % (next_seq - head_seq + 1));
        sta_addr = pick_addr();
        if (exe_seq >= 0 && ($urandom % 2) == 0) begin
            // R6: same-cycle execution and matching store
            sta_addr = exe_addr;
            st_seq   = head_seq + int'($urandom % (exe_seq - head_seq + 1));
        end
        sta_tag = lq_tag_t'(st_seq % NTAG);
        cmt_req = (($urandom % 100) < p_cmt);
        #1;
        exp_rdy = (mq.size() < LQ_DEPTH);
        exp_ok  = cmt_req && (mq.size() > 0) && mq[0].done;
        exp_fl  = exp_ok && mq[0].trap;
        check("R2 alloc_rdy", 64'(alloc_rdy), 64'(exp_rdy));
        check("R8 R9 alloc_tag", 64'(alloc_tag), 64'(next_seq % NTAG));
        check("R3 R4 cmt_ok", 64'(cmt_ok), 64'(exp_ok));
        check("R5 R6 R10 flush_vld", 64'(flush_vld), 64'(exp_fl));
        if (exp_fl) check("R7 flush_pc", 64'(flush_pc), 64'(mq[0].pc));
        @(posedge clk);
        if (exp_fl) begin
            n_flush++;
            next_seq = mq[0].seq + 1;
            mq.delete();
        end else begin
            if (sta_vld) begin
                foreach (mq[k]) begin
                    bit                d;
                    logic [ADDR_W-1:0] a;
                    d = mq[k].done;
                    a = mq[k].addr;
                    if (exe_seq == mq[k].seq) begin
                        d = 1'b1;
                        a = exe_addr;
                    end
                    if (d && mq[k].seq >= st_seq && (a / 4) == (sta_addr / 4))
                        mq[k].trap = 1'b1;
                end
            end
            if (exe_seq >= 0) begin
                foreach (mq[k]) begin
                    if (mq[k].seq == exe_seq) begin
                        mq[k].done = 1'b1;
                        mq[k].addr = exe_addr;
                    end
                end
            end
            if (exp_ok) void'(mq.pop_front());
            if (alloc_vld && exp_rdy) begin
                mdl_t e;
                e.seq  = next_seq;
                e.pc   = alloc_pc;
                e.done = 1'b0;
                e.trap = 1'b0;
                e.addr = '0;
                mq.push_back(e);
                next_seq++;
            end
        end
    endtask

    initial begin
        #(CLK_P * WDOG);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        checks = 0; errors = 0; finished = 0; next_seq = 0; n_flush = 0;
        rst = 1'b1;
        alloc_vld = 1'b1; alloc_pc = '0; exe_vld = 1'b0; exe_tag = '0; exe_addr = '0;
        sta_vld = 1'b0; sta_tag = '0; sta_addr = '0; cmt_req = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        alloc_vld = 1'b0;
        #1;
        // R1: state right after reset
        check("R1 alloc_rdy", 64'(alloc_rdy), 64'd1);
        check("R1 alloc_tag", 64'(alloc_tag), 64'd0);
        check("R1 cmt_ok", 64'(cmt_ok), 64'd0);
        check("R1 flush_vld", 64'(flush_vld), 64'd0);
        // R2: fill beyond capacity with no retirement
        for (int c = 0; c < 60; c++) step(90, 0, 0, 0);
        check("R2 full after fill", 64'(alloc_rdy), 64'd0);
        // mixed traffic, tags wrap many times (R9)
        for (int c = 0; c < 3000; c++) step(55, 60, 35, 60);
        // drain-heavy phase
        for (int c = 0; c < 300; c++) step(20, 80, 30, 90);
        check("R7 flushes observed", 64'(n_flush > 0), 64'd1);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule